// File: doc/BRIEF.md
# Two-Wire Indexed Register Target

This block is a target on a two-wire SMBus. It gives a host controller read and write access to a small bank of configuration bytes. SCL and SDA are brought into the core clock domain through synchronizer chains. The block finds start, stop and repeated-start conditions, matches a 7-bit device address and acknowledges the bytes it accepts. It drives SDA only by pulling it low, through an output-enable.

The command byte picks one of two access styles. When command bit 7 is set, bits 6:0 give a register offset. One or more bytes, such as a low/high word pair, are then read or written at that offset and the offsets that follow it. When bit 7 is clear, the transfer is a block transfer that always starts at register 0. A write sends a byte count before the data. A read returns the number of implemented registers and then the data. The register storage is outside this block. The block reaches it through a plain port with address, write data, a single-cycle write strobe and combinational read data.

Top module: `smbreg_target`

## Requirements
- R1: After reset the block does not pull SDA low and does not raise the write strobe, and it never pulls SDA low while idle.
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR by pulling SDA low during the ninth clock. For any other address it leaves SDA released, and it ignores every following bit until the next start condition.
- R3: An indexed write (command bit 7 = 1) stores the received data byte, taken most significant bit first, at the offset given by command bits 6:0.
- R4: In an indexed write of two data bytes, the first byte goes to the command offset and the second byte to that offset plus one.
- R5: An indexed read uses a repeated start and a read address, and returns the register at the command offset, most significant bit first.
- R6: In an indexed read, each byte that the host acknowledges is followed by the register at the next offset. After a host NACK the block releases SDA.
- R7: In a block write (command bit 7 = 0), the first byte after the command is a byte count and is not stored. The data bytes that follow go to offsets 0, 1, 2 and upward, whatever the value of command bits 6:0.
- R8: A block read first returns a byte count equal to NUM_REGS, then the registers from offset 0 upward.
- R9: A read at an offset of NUM_REGS or higher returns 0x00. A write at such an offset is acknowledged but raises no write strobe, and every strobe carries an address below NUM_REGS.
- R10: A stop condition at any point ends the transaction and releases SDA. Bytes acknowledged before it stay written, and a partial byte is discarded.
- R11: During a write the block acknowledges the command byte, the count byte and every data byte, and it pulls SDA low only while SCL is low.
- R12: The write strobe lasts one core clock cycle per accepted data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | 7 | Register offset currently addressed |
| reg_wdata | output | 8 | Byte to store on a write strobe |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
The bench writes and reads through both access styles. A data byte of 0x5A is asymmetric, so it shows that bits are shifted most significant bit first. Words with distinct low and high halves show whether the offset steps in the right direction. A block write whose count differs from any data value shows whether the count byte was stored by mistake. A block read that runs past the last register, against a register file that returns 0xEE out of range, shows that the zero fill comes from the block and not from the storage. A foreign address followed by traffic, and a stop cut into the middle of a byte, show that stray bits are ignored while bytes that were already acknowledged stay written.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
   localparam int OFS_W = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_A,
      ST_CMD,
      ST_ACK_C,
      ST_RX,
      ST_ACK_W,
      ST_TX,
      ST_MACK
   } smb_state_t;
endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_d
);
   logic chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("smbreg_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q_d <= RST_VAL;
      else        q_d <= chain[STAGES-1];

   assign q = chain[STAGES-1];
endmodule

// File: rtl/smbreg_cond.sv
module smbreg_cond (
   input  logic scl_q,
   input  logic scl_d,
   input  logic sda_q,
   input  logic sda_d,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_high;

   assign scl_high  = scl_q & scl_d;
   assign start_det = scl_high & sda_d & ~sda_q;
   assign stop_det  = scl_high & ~sda_d & sda_q;
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
endmodule

// File: rtl/smbreg_target.sv
module smbreg_target
   import smbreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 6,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [OFS_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   input  logic [7:0]       reg_rdata
);
   localparam logic [7:0] REG_COUNT = 8'(NUM_REGS);

   if (NUM_REGS < 1 || NUM_REGS > 128) begin : g_bad_nregs
      $error("smbreg_target: NUM_REGS must lie in 1..128");
   end

   logic scl_s, scl_p, sda_s, sda_p;
   logic start_det, stop_det, scl_rise, scl_fall;

   smbreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_d(scl_p));
   smbreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_d(sda_p));

   smbreg_cond u_cond (
      .scl_q(scl_s), .scl_d(scl_p), .sda_q(sda_s), .sda_d(sda_p),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall));

   smb_state_t       state;
   logic [7:0]       sh;
   logic [3:0]       bcnt;
   logic             rd_mode, cnt_pend, nak, we_q;
   logic [OFS_W-1:0] ptr;
   logic [7:0]       wd_q;
   logic             in_range;
   logic [7:0]       tx_byte;

   assign in_range  = {1'b0, ptr} < REG_COUNT;
   assign tx_byte   = cnt_pend ? REG_COUNT : (in_range ? reg_rdata : 8'h00);
   assign reg_addr  = ptr;
   assign reg_wdata = wd_q;
   assign reg_we    = we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sh       <= '0;
         bcnt     <= '0;
         rd_mode  <= 1'b0;
         cnt_pend <= 1'b0;
         nak      <= 1'b0;
         ptr      <= '0;
         wd_q     <= '0;
         we_q     <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_RX: begin
                  if (scl_rise) begin
                     sh   <= {sh[6:0], sda_s};
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall && bcnt == 4'd8) begin
                     bcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           sda_oe  <= 1'b1;
                           rd_mode <= sh[0];
                           state   <= ST_ACK_A;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_CMD) begin
                        sda_oe   <= 1'b1;
                        state    <= ST_ACK_C;
                        ptr      <= sh[7] ? sh[6:0] : '0;
                        cnt_pend <= ~sh[7];
                     end else begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK_W;
                        if (!cnt_pend) begin
                           we_q <= in_range;
                           wd_q <= sh;
                        end
                     end
                  end
               end
               ST_ACK_A: if (scl_fall) begin
                  if (rd_mode) begin
                     sh     <= tx_byte;
                     sda_oe <= ~tx_byte[7];
                     state  <= ST_TX;
                     if (cnt_pend) cnt_pend <= 1'b0;
                     else          ptr      <= ptr + 1'b1;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_CMD;
                  end
               end
               ST_ACK_C: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_RX;
               end
               ST_ACK_W: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_RX;
                  if (cnt_pend) cnt_pend <= 1'b0;
                  else          ptr      <= ptr + 1'b1;
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        bcnt   <= '0;
                        state  <= ST_MACK;
                     end else begin
                        sda_oe <= ~sh[6];
                        sh     <= {sh[6:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     nak <= sda_s;
                  end else if (scl_fall) begin
                     if (!nak) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        state  <= ST_TX;
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else          ptr      <= ptr + 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: an idle target never holds the data line
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe);

   // R11: the target only starts pulling SDA while the clock line is low
   p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10: a stop releases the line and returns to idle
   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && state == ST_IDLE));

   // R12: one strobe cycle per accepted byte
   p_we_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R9: strobes only reach implemented registers
   p_we_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> ({1'b0, reg_addr} < REG_COUNT));
endmodule

// File: tb/smbreg_target_bench.sv
module smbreg_target_bench;
   localparam logic [6:0] DEV  = 7'h69;
   localparam int         NREG = 6;
   localparam int         HALF = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic       sda_line;
   logic [7:0] mem [NREG];
   int         n_chk = 0;
   int         n_fail = 0;
   int         we_cnt = 0;
   int         cyc = 0;

   always #2.5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = (reg_addr < 7'(NREG)) ? mem[reg_addr[2:0]] : 8'hEE;

   smbreg_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .SYNC_STAGES(2)) u_smbreg_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= 8'hC0 + 8'(i);
      end else if (reg_we && reg_addr < 7'(NREG)) begin
         mem[reg_addr[2:0]] <= reg_wdata;
      end

   always @(posedge clk) begin
      if (reg_we) we_cnt <= we_cnt + 1;
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(); repeat (HALF) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
      sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
      end
      hw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack_n);
      send_bits(b, 8);
      sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
      ack_n = sda_line;
      scl_m = 1'b0; hw();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hw(); scl_m = 1'b1; hw(); b[i] = sda_line; scl_m = 1'b0;
      end
      hw(); sda_m = give_ack ? 1'b0 : 1'b1;
      hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw(); sda_m = 1'b1;
   endtask

   task automatic open_read(input logic [7:0] cmd);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R2 address ack", a, 1'b0);
      send_byte(cmd, a);         chk("R11 command ack", a, 1'b0);
      bus_start();
      send_byte({DEV, 1'b1}, a); chk("R5 read address ack", a, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 sda released after reset", sda_oe, 1'b0);
      chk("R1 no strobe after reset", reg_we, 1'b0);
   endtask

   task automatic t_wrong_address();
      logic a; int w0;
      w0 = we_cnt;
      bus_start();
      send_byte({7'h12, 1'b0}, a); chk("R2 foreign address nack", a, 1'b1);
      send_byte(8'h81, a);         chk("R2 ignored byte nack", a, 1'b1);
      send_byte(8'h99, a);         chk("R2 ignored data nack", a, 1'b1);
      bus_stop();
      chk("R2 no strobe", we_cnt - w0, 0);
      chk("R2 register untouched", mem[1], 8'hC1);
   endtask

   task automatic t_byte_write();
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R2 address ack", a, 1'b0);
      send_byte(8'h82, a);       chk("R11 command ack", a, 1'b0);
      send_byte(8'h5A, a);       chk("R11 data ack", a, 1'b0);
      bus_stop();
      chk("R3 byte stored msb first", mem[2], 8'h5A);
   endtask

   task automatic t_byte_read();
      logic [7:0] d;
      open_read(8'h82);
      recv_byte(1'b0, d);
      chk("R5 byte read", d, 8'h5A);
      hw();
      chk("R6 released after nack", sda_line, 1'b1);
      bus_stop();
   endtask

   task automatic t_word_write();
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h83, a);
      send_byte(8'h11, a); chk("R11 low byte ack", a, 1'b0);
      send_byte(8'h22, a); chk("R11 high byte ack", a, 1'b0);
      bus_stop();
      chk("R4 low byte at offset", mem[3], 8'h11);
      chk("R4 high byte at offset+1", mem[4], 8'h22);
      chk("R4 neighbour kept", mem[2], 8'h5A);
   endtask

   task automatic t_word_read();
      logic [7:0] d;
      open_read(8'h83);
      recv_byte(1'b1, d); chk("R6 low byte", d, 8'h11);
      recv_byte(1'b0, d); chk("R6 high byte", d, 8'h22);
      hw();
      chk("R6 released after nack", sda_line, 1'b1);
      bus_stop();
   endtask

   task automatic t_block_write();
      logic a; int w0;
      w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h00, a); chk("R11 block command ack", a, 1'b0);
      send_byte(8'h03, a); chk("R11 count ack", a, 1'b0);
      send_byte(8'hA0, a);
      send_byte(8'hA1, a);
      send_byte(8'hA2, a); chk("R11 last data ack", a, 1'b0);
      bus_stop();
      chk("R7 byte 0", mem[0], 8'hA0);
      chk("R7 byte 1", mem[1], 8'hA1);
      chk("R7 byte 2", mem[2], 8'hA2);
      chk("R7 count not stored", mem[3], 8'h11);
      chk("R7 three strobes", we_cnt - w0, 3);
   endtask

   task automatic t_block_read();
      logic [7:0] d;
      logic [7:0] exp [8];
      exp[0] = 8'hA0; exp[1] = 8'hA1; exp[2] = 8'hA2; exp[3] = 8'h11;
      exp[4] = 8'h22; exp[5] = 8'hC5; exp[6] = 8'h00; exp[7] = 8'h00;
      open_read(8'h00);
      recv_byte(1'b1, d); chk("R8 count", d, 8'(NREG));
      for (int i = 0; i < 8; i++) begin
         recv_byte(i < 7, d);
         if (i < NREG) chk("R8 block data", d, exp[i]);
         else          chk("R9 past end reads zero", d, exp[i]);
      end
      bus_stop();
   endtask

   task automatic t_past_end();
      logic a; logic [7:0] d; int w0;
      w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h86, a);
      send_byte(8'h77, a); chk("R9 out of range write acked", a, 1'b0);
      bus_stop();
      chk("R9 no strobe past end", we_cnt - w0, 0);
      open_read(8'h86);
      recv_byte(1'b0, d); chk("R9 indexed read past end", d, 8'h00);
      bus_stop();
   endtask

   task automatic t_abort();
      logic a; int w0;
      w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h80, a);
      send_byte(8'h3C, a);
      send_bits(8'hFF, 4);
      bus_stop();
      chk("R10 acked byte committed", mem[0], 8'h3C);
      chk("R10 partial byte dropped", we_cnt - w0, 1);
      chk("R10 line released", sda_line, 1'b1);
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R10 next transaction acked", a, 1'b0);
      send_byte(8'h81, a);
      send_byte(8'h4D, a);
      bus_stop();
      chk("R10 next write lands", mem[1], 8'h4D);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_reset();
      t_wrong_address();
      t_byte_write();
      t_byte_read();
      t_word_write();
      t_word_read();
      t_block_write();
      t_block_read();
      t_past_end();
      t_abort();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule